// File: doc/BRIEF.md
# PWM Time-Base Counter with Action Qualifier

This block generates two pulse-width-modulated outputs from a single 16-bit time-base counter. A two-stage clock prescaler produces a tick. The counter steps once per tick in one of three counting modes: rising, falling or rising-then-falling. On every step the new count is compared against zero, the period and two compare values. Each match is qualified by the direction of the step that reached it. For each output, a per-event action table turns these matches into edges.

The counter can be aligned to another time base. A sync pulse, either from a neighbouring block or from a software strobe, loads a phase value into the counter. In rising-then-falling mode a configuration bit chooses the direction in which counting resumes after the load. A selectable sync output lets several of these blocks be chained. The host drives the configuration inputs directly, and a run enable freezes the time base.

Top module: `pwm_tbaq`

## Requirements
- R1: The counter advances once every H*C clock cycles while `run_en` is high. H is 1 for `hs_div_sel`=0 and 2*k for `hs_div_sel`=k otherwise. C is 2^k for `ck_div_sel`=k. The prescaler restarts from zero whenever `run_en` is low or a phase load occurs.
- R2: With `count_mode`=00 (rising), each step adds one. When the count is at or above `period`, the next step returns it to 0. `cnt_dir_up` reads 1.
- R3: With `count_mode`=01 (falling), each step subtracts one. A step from 0 loads `period`. `cnt_dir_up` reads 0.
- R4: With `count_mode`=10 (rising-then-falling), the count turns downward after reaching `period` and upward after reaching 0. `cnt_dir_up` gives the direction of the last step. With `count_mode`=11 the counter does not step.
- R5: While `run_en` is low and no phase load occurs, `cnt`, `cnt_dir_up` and both PWM outputs hold their values.
- R6: When `phase_en` is high and `sync_in` or `sw_sync` is high at a clock edge, `cnt` takes `phase_val` at that edge and no match event is raised. The direction becomes up in mode 00, down in mode 01, and `phase_dir_up` in mode 10.
- R7: `evt_zero` and `evt_prd` are high for the one cycle after an edge at which the counter stepped to 0 or to `period` respectively.
- R8: Each action table has six 2-bit fields: [1:0] step to zero, [3:2] step to period, [5:4] match A rising, [7:6] match A falling, [9:8] match B rising, [11:10] match B falling. Code 00 does nothing, 01 drives low, 10 drives high and 11 inverts. The output changes at the same edge as the count step.
- R9: When several events fire on one step, only the first non-00 action in the order zero, period, match B, match A is applied.
- R10: After reset `cnt` is 0, `cnt_dir_up` is 1, and all strobes and both outputs are low. The package default tables (A: 12'h021, B: 12'h108) give A low at zero and high at match A rising, and B high at period and low at match B rising.
- R11: `sync_out_sel` selects the sync output: 00 repeats `sync_in`|`sw_sync` one cycle later, 01 pulses on a step to zero, 10 pulses on a match B step, and 11 holds it low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run_en | input | 1 | Time-base run enable |
| period | input | 16 | Count period |
| cmp_a | input | 16 | Compare value A |
| cmp_b | input | 16 | Compare value B |
| hs_div_sel | input | 3 | First prescaler stage code |
| ck_div_sel | input | 3 | Second prescaler stage code |
| count_mode | input | 2 | Counting mode |
| phase_en | input | 1 | Enable phase load on sync |
| phase_val | input | 16 | Phase value loaded on sync |
| phase_dir_up | input | 1 | Direction after sync in mode 10 |
| sync_in | input | 1 | Sync pulse from neighbour |
| sw_sync | input | 1 | Software sync strobe |
| sync_out_sel | input | 2 | Sync output source |
| act_a | input | 12 | Action table for output A |
| act_b | input | 12 | Action table for output B |
| cnt | output | 16 | Counter value |
| cnt_dir_up | output | 1 | Direction of last step |
| evt_zero | output | 1 | Stepped-to-zero strobe |
| evt_prd | output | 1 | Stepped-to-period strobe |
| sync_out | output | 1 | Sync output |
| pwm_a | output | 1 | PWM output A |
| pwm_b | output | 1 | PWM output B |

## Verification
A corrupted count or direction register shows on `cnt` and `cnt_dir_up` at the very next step. It then shifts every later match, so the PWM edges move within one period. A prescaler fault stretches or shortens the spacing between steps and is caught at the first tick. A wrong output register or priority choice shows on `pwm_a` or `pwm_b` at the edge of the step concerned, because the bench compares every port against its own cycle model in every cycle.

// File: rtl/pwm_tbaq_pkg.sv
package pwm_tbaq_pkg;
  localparam int CNT_W     = 16;
  localparam int HS_SEL_W  = 3;
  localparam int CK_SEL_W  = 3;
  localparam int ACT_W     = 2;
  localparam int N_EVT     = 6;
  localparam int TBL_W     = ACT_W * N_EVT;
  localparam int N_CH      = 2;

  typedef enum logic [1:0] {ACT_NONE, ACT_CLR, ACT_SET, ACT_TGL} act_e;
  typedef enum logic [1:0] {MODE_UP, MODE_DOWN, MODE_UPDN, MODE_FREEZE} mode_e;
  typedef enum logic [1:0] {SO_PASS, SO_ZERO, SO_CMPB, SO_OFF} so_e;

  // bit 0 is the step-to-zero event, matching the action table field order
  typedef struct packed {
    logic cbd;
    logic cbu;
    logic cad;
    logic cau;
    logic prd;
    logic zero;
  } evt_t;

  localparam logic [TBL_W-1:0] ACT_A_DFLT = 12'h021;
  localparam logic [TBL_W-1:0] ACT_B_DFLT = 12'h108;
endpackage

// File: rtl/pwm_tbaq_prescale.sv
module pwm_tbaq_prescale
  import pwm_tbaq_pkg::*;
#(
  parameter int HS_W = HS_SEL_W,
  parameter int CK_W = CK_SEL_W
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            run_en,
  input  logic            restart,
  input  logic [HS_W-1:0] hs_sel,
  input  logic [CK_W-1:0] ck_sel,
  output logic            tick
);
  localparam int HS_CNT_W = HS_W + 1;
  localparam int CK_CNT_W = (1 << CK_W) - 1;

  logic [HS_CNT_W-1:0] hs_q, hs_d, hs_last;
  logic [CK_CNT_W-1:0] ck_q, ck_d, ck_last;
  logic                hs_end, ck_end;

  // first stage divides by 1 or by twice its code
  always_comb begin
    if (hs_sel == '0) hs_last = '0;
    else              hs_last = {hs_sel, 1'b0} - 1'b1;
  end

  // second stage divides by a power of two
  assign ck_last = ~({CK_CNT_W{1'b1}} << ck_sel);

  assign hs_end = (hs_q >= hs_last);
  assign ck_end = (ck_q >= ck_last);
  assign tick   = run_en & hs_end & ck_end;

  always_comb begin
    hs_d = hs_q;
    ck_d = ck_q;
    if (!run_en || restart) begin
      hs_d = '0;
      ck_d = '0;
    end else if (hs_end) begin
      hs_d = '0;
      ck_d = ck_end ? '0 : ck_q + 1'b1;
    end else begin
      hs_d = hs_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hs_q <= '0;
      ck_q <= '0;
    end else begin
      hs_q <= hs_d;
      ck_q <= ck_d;
    end
  end
endmodule

// File: rtl/pwm_tbaq_counter.sv
module pwm_tbaq_counter
  import pwm_tbaq_pkg::*;
#(
  parameter int W = CNT_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  logic         load,
  input  mode_e        mode,
  input  logic [W-1:0] period,
  input  logic [W-1:0] phase_val,
  input  logic         phase_dir_up,
  input  logic [W-1:0] cmp_a,
  input  logic [W-1:0] cmp_b,
  output logic [W-1:0] cnt,
  output logic         dir_up,
  output evt_t         evt_nx,
  output logic         zero_q,
  output logic         prd_q
);
  logic [W-1:0] cnt_q, cnt_d, step_cnt;
  logic         dir_q, dir_d, step_dir, upd_en;

  // value and direction of one count step in the current mode
  always_comb begin
    step_cnt = cnt_q;
    step_dir = dir_q;
    unique case (mode)
      MODE_UP: begin
        step_dir = 1'b1;
        step_cnt = (cnt_q >= period) ? '0 : cnt_q + 1'b1;
      end
      MODE_DOWN: begin
        step_dir = 1'b0;
        step_cnt = (cnt_q == '0) ? period : cnt_q - 1'b1;
      end
      MODE_UPDN: begin
        if (dir_q) begin
          if (cnt_q >= period) begin
            step_dir = 1'b0;
            step_cnt = (cnt_q == '0) ? '0 : cnt_q - 1'b1;
          end else begin
            step_cnt = cnt_q + 1'b1;
          end
        end else if (cnt_q == '0) begin
          step_dir = 1'b1;
          step_cnt = (period == '0) ? '0 : W'(1);
        end else begin
          step_cnt = cnt_q - 1'b1;
        end
      end
      default: ;
    endcase
  end

  // phase load beats a step; events come only from steps
  always_comb begin
    cnt_d  = cnt_q;
    dir_d  = dir_q;
    evt_nx = '0;
    if (load) begin
      cnt_d = phase_val;
      unique case (mode)
        MODE_UP:   dir_d = 1'b1;
        MODE_DOWN: dir_d = 1'b0;
        MODE_UPDN: dir_d = phase_dir_up;
        default:   dir_d = dir_q;
      endcase
    end else if (tick && (mode != MODE_FREEZE)) begin
      cnt_d       = step_cnt;
      dir_d       = step_dir;
      evt_nx.zero = (step_cnt == '0);
      evt_nx.prd  = (step_cnt == period);
      evt_nx.cau  = (step_cnt == cmp_a) &  step_dir;
      evt_nx.cad  = (step_cnt == cmp_a) & ~step_dir;
      evt_nx.cbu  = (step_cnt == cmp_b) &  step_dir;
      evt_nx.cbd  = (step_cnt == cmp_b) & ~step_dir;
    end
  end

  assign upd_en = load | tick;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      dir_q <= 1'b1;
    end else if (upd_en) begin
      cnt_q <= cnt_d;
      dir_q <= dir_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      zero_q <= 1'b0;
      prd_q  <= 1'b0;
    end else begin
      zero_q <= evt_nx.zero;
      prd_q  <= evt_nx.prd;
    end
  end

  assign cnt    = cnt_q;
  assign dir_up = dir_q;
endmodule

// File: rtl/pwm_tbaq_aq.sv
module pwm_tbaq_aq
  import pwm_tbaq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  evt_t             evt,
  input  logic [TBL_W-1:0] tbl,
  output logic             pwm
);
  logic [N_EVT-1:0] ev_v;
  act_e             sel;
  logic             out_q, out_d, out_en;

  // rank 0 is the strongest: zero, period, B up, B down, A up, A down
  function automatic int rank_to_evt(input int rank);
    case (rank)
      0:       return 0;
      1:       return 1;
      2:       return 4;
      3:       return 5;
      4:       return 2;
      default: return 3;
    endcase
  endfunction

  assign ev_v = evt;

  // walk from weakest to strongest so the strongest active action remains
  always_comb begin
    sel = ACT_NONE;
    for (int r = N_EVT - 1; r >= 0; r--) begin
      if (ev_v[rank_to_evt(r)] &&
          (act_e'(tbl[rank_to_evt(r)*ACT_W +: ACT_W]) != ACT_NONE))
        sel = act_e'(tbl[rank_to_evt(r)*ACT_W +: ACT_W]);
    end
  end

  always_comb begin
    unique case (sel)
      ACT_CLR: out_d = 1'b0;
      ACT_SET: out_d = 1'b1;
      ACT_TGL: out_d = ~out_q;
      default: out_d = out_q;
    endcase
  end

  assign out_en = (sel != ACT_NONE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      out_q <= 1'b0;
    else if (out_en) out_q <= out_d;
  end

  assign pwm = out_q;
endmodule

// File: rtl/pwm_tbaq.sv
module pwm_tbaq
  import pwm_tbaq_pkg::*;
#(
  parameter int W    = CNT_W,
  parameter int HS_W = HS_SEL_W,
  parameter int CK_W = CK_SEL_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_en,
  input  logic [W-1:0]     period,
  input  logic [W-1:0]     cmp_a,
  input  logic [W-1:0]     cmp_b,
  input  logic [HS_W-1:0]  hs_div_sel,
  input  logic [CK_W-1:0]  ck_div_sel,
  input  logic [1:0]       count_mode,
  input  logic             phase_en,
  input  logic [W-1:0]     phase_val,
  input  logic             phase_dir_up,
  input  logic             sync_in,
  input  logic             sw_sync,
  input  logic [1:0]       sync_out_sel,
  input  logic [TBL_W-1:0] act_a,
  input  logic [TBL_W-1:0] act_b,
  output logic [W-1:0]     cnt,
  output logic             cnt_dir_up,
  output logic             evt_zero,
  output logic             evt_prd,
  output logic             sync_out,
  output logic             pwm_a,
  output logic             pwm_b
);
  logic                  rst_s1, rst_s2;
  logic                  tick, sync_hit, load;
  evt_t                  evt_nx;
  logic [N_CH-1:0][TBL_W-1:0] tbls;
  logic [N_CH-1:0]       pwm_v;
  logic                  so_q, so_d;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1 <= 1'b0;
      rst_s2 <= 1'b0;
    end else begin
      rst_s1 <= 1'b1;
      rst_s2 <= rst_s1;
    end
  end

  assign sync_hit = sync_in | sw_sync;
  assign load     = phase_en & sync_hit;

  pwm_tbaq_prescale #(.HS_W(HS_W), .CK_W(CK_W)) u_pre (
    .clk     (clk),
    .rst_n   (rst_s2),
    .run_en  (run_en),
    .restart (load),
    .hs_sel  (hs_div_sel),
    .ck_sel  (ck_div_sel),
    .tick    (tick)
  );

  pwm_tbaq_counter #(.W(W)) u_cnt (
    .clk          (clk),
    .rst_n        (rst_s2),
    .tick         (tick),
    .load         (load),
    .mode         (mode_e'(count_mode)),
    .period       (period),
    .phase_val    (phase_val),
    .phase_dir_up (phase_dir_up),
    .cmp_a        (cmp_a),
    .cmp_b        (cmp_b),
    .cnt          (cnt),
    .dir_up       (cnt_dir_up),
    .evt_nx       (evt_nx),
    .zero_q       (evt_zero),
    .prd_q        (evt_prd)
  );

  assign tbls[0] = act_a;
  assign tbls[1] = act_b;

  for (genvar ch = 0; ch < N_CH; ch++) begin : g_ch
    pwm_tbaq_aq u_aq (
      .clk   (clk),
      .rst_n (rst_s2),
      .evt   (evt_nx),
      .tbl   (tbls[ch]),
      .pwm   (pwm_v[ch])
    );
  end

  assign pwm_a = pwm_v[0];
  assign pwm_b = pwm_v[1];

  always_comb begin
    unique case (so_e'(sync_out_sel))
      SO_PASS: so_d = sync_hit;
      SO_ZERO: so_d = evt_nx.zero;
      SO_CMPB: so_d = evt_nx.cbu | evt_nx.cbd;
      default: so_d = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_s2) begin
    if (!rst_s2) so_q <= 1'b0;
    else         so_q <= so_d;
  end

  assign sync_out = so_q;
endmodule

// File: rtl/pwm_tbaq_chk.sv
module pwm_tbaq_chk #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst_n,
  input logic         run_en,
  input logic [W-1:0] period,
  input logic         phase_en,
  input logic [W-1:0] phase_val,
  input logic         sync_in,
  input logic         sw_sync,
  input logic [1:0]   count_mode,
  input logic [1:0]   sync_out_sel,
  input logic [W-1:0] cnt,
  input logic         cnt_dir_up,
  input logic         evt_zero,
  input logic         evt_prd,
  input logic         sync_out
);
  logic rq1, rq2, ld;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rq1 <= 1'b0;
      rq2 <= 1'b0;
    end else begin
      rq1 <= 1'b1;
      rq2 <= rq1;
    end
  end

  assign ld = phase_en & (sync_in | sw_sync);

  assert_zero_strobe_R7: assert property (@(posedge clk) disable iff (!rq2)
    evt_zero |-> (cnt == '0));

  assert_prd_strobe_R7: assert property (@(posedge clk) disable iff (!rq2)
    evt_prd |-> (cnt == $past(period)));

  assert_hold_R5: assert property (@(posedge clk) disable iff (!rq2)
    (!run_en && !ld) |=> $stable(cnt));

  assert_phase_load_R6: assert property (@(posedge clk) disable iff (!rq2)
    ld |=> (cnt == $past(phase_val)));

  assert_sync_off_R11: assert property (@(posedge clk) disable iff (!rq2)
    sync_out |-> ($past(sync_out_sel) != 2'b11));

  assert_up_dir_R2: assert property (@(posedge clk) disable iff (!rq2)
    (($past(count_mode) == 2'b00) && (cnt != $past(cnt))) |-> cnt_dir_up);

  assert_down_dir_R3: assert property (@(posedge clk) disable iff (!rq2)
    (($past(count_mode) == 2'b01) && (cnt != $past(cnt))) |-> !cnt_dir_up);
endmodule

bind pwm_tbaq pwm_tbaq_chk #(.W(W)) i_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .run_en       (run_en),
  .period       (period),
  .phase_en     (phase_en),
  .phase_val    (phase_val),
  .sync_in      (sync_in),
  .sw_sync      (sw_sync),
  .count_mode   (count_mode),
  .sync_out_sel (sync_out_sel),
  .cnt          (cnt),
  .cnt_dir_up   (cnt_dir_up),
  .evt_zero     (evt_zero),
  .evt_prd      (evt_prd),
  .sync_out     (sync_out)
);

// File: tb/test_pwm_tbaq.sv
module test_pwm_tbaq;
  logic        clk, rst_n, run_en, phase_en, phase_dir_up, sync_in, sw_sync;
  logic [15:0] period, cmp_a, cmp_b, phase_val, cnt;
  logic [2:0]  hs_div_sel, ck_div_sel;
  logic [1:0]  count_mode, sync_out_sel;
  logic [11:0] act_a, act_b;
  logic        cnt_dir_up, evt_zero, evt_prd, sync_out, pwm_a, pwm_b;

  int n_chk, n_fail;
  bit chk_on, done;

  // bench model state
  int m_pc, m_cnt;
  bit m_dir, m_a, m_b, m_ez, m_ep, m_so;

  pwm_tbaq i_pwm_tbaq (.*);

  initial clk = 1'b0;
  always #5 clk = ~clk;

  function automatic int hs_div(input int s);
    return (s == 0) ? 1 : 2 * s;
  endfunction

  // field e of the table is bits [2e+1:2e]; strongest first
  function automatic bit apply_act(input bit cur, input logic [11:0] tbl,
                                   input logic [5:0] ev);
    int order [6] = '{0, 1, 4, 5, 2, 3};
    for (int i = 0; i < 6; i++) begin
      int e;
      logic [1:0] a;
      e = order[i];
      a = tbl[e*2 +: 2];
      if (ev[e] && a != 2'b00) begin
        if (a == 2'b01) return 1'b0;
        if (a == 2'b10) return 1'b1;
        return !cur;
      end
    end
    return cur;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_pc = 0; m_cnt = 0; m_dir = 1; m_a = 0; m_b = 0;
      m_ez = 0; m_ep = 0; m_so = 0;
    end else begin
      int n, nc;
      bit ld, tk, nd;
      logic [5:0] ev;
      n  = hs_div(int'(hs_div_sel)) * (1 << ck_div_sel);
      ld = phase_en && (sync_in || sw_sync);
      tk = run_en && (m_pc >= n - 1);
      ev = '0; nc = m_cnt; nd = m_dir;
      if (ld) begin
        nc = int'(phase_val);
        if (count_mode == 2'b00) nd = 1;
        else if (count_mode == 2'b01) nd = 0;
        else if (count_mode == 2'b10) nd = phase_dir_up;
      end else if (tk && count_mode != 2'b11) begin
        if (count_mode == 2'b00) begin
          nd = 1; nc = (m_cnt >= int'(period)) ? 0 : m_cnt + 1;
        end else if (count_mode == 2'b01) begin
          nd = 0; nc = (m_cnt == 0) ? int'(period) : m_cnt - 1;
        end else if (m_dir) begin
          if (m_cnt >= int'(period)) begin nd = 0; nc = (m_cnt == 0) ? 0 : m_cnt - 1; end
          else nc = m_cnt + 1;
        end else begin
          if (m_cnt == 0) begin nd = 1; nc = (period == 0) ? 0 : 1; end
          else nc = m_cnt - 1;
        end
        ev[0] = (nc == 0);
        ev[1] = (nc == int'(period));
        ev[2] = (nc == int'(cmp_a)) && nd;
        ev[3] = (nc == int'(cmp_a)) && !nd;
        ev[4] = (nc == int'(cmp_b)) && nd;
        ev[5] = (nc == int'(cmp_b)) && !nd;
      end
      m_pc = (!run_en || ld || tk) ? 0 : m_pc + 1;
      case (sync_out_sel)
        2'b00:   m_so = sync_in || sw_sync;
        2'b01:   m_so = ev[0];
        2'b10:   m_so = ev[4] || ev[5];
        default: m_so = 0;
      endcase
      m_a = apply_act(m_a, act_a, ev);
      m_b = apply_act(m_b, act_b, ev);
      m_ez = ev[0]; m_ep = ev[1];
      m_cnt = nc; m_dir = nd;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s at %0t: actual %0d expected %0d", req, $time, act, exp);
    end
  endtask

  // every cycle: ports against the model
  always @(negedge clk) begin
    if (chk_on) begin
      chk("R2 R3 R4 R6 cnt", int'(cnt), m_cnt);
      chk("R4 R6 direction", int'(cnt_dir_up), int'(m_dir));
      chk("R7 zero strobe", int'(evt_zero), int'(m_ez));
      chk("R7 period strobe", int'(evt_prd), int'(m_ep));
      chk("R11 sync out", int'(sync_out), int'(m_so));
      chk("R8 R9 pwm_a", int'(pwm_a), int'(m_a));
      chk("R8 R9 pwm_b", int'(pwm_b), int'(m_b));
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic phase_load(input logic [15:0] v, input bit d);
    phase_en = 1; sync_in = 1; phase_val = v; phase_dir_up = d; run_en = 0;
    cyc(1);
    sync_in = 0; phase_en = 0;
  endtask

  initial begin
    int base;
    void'($urandom(32'd4711));
    n_chk = 0; n_fail = 0; chk_on = 0; done = 0;
    rst_n = 0; run_en = 0; period = 0; cmp_a = 0; cmp_b = 0;
    hs_div_sel = 0; ck_div_sel = 0; count_mode = 2'b00; phase_en = 0;
    phase_val = 0; phase_dir_up = 0; sync_in = 0; sw_sync = 0;
    sync_out_sel = 2'b11;
    act_a = 12'h021; act_b = 12'h108;
    cyc(3); rst_n = 1; cyc(3);
    chk_on = 1;

    // R10 reset state
    chk("R10 reset cnt", int'(cnt), 0);
    chk("R10 reset dir", int'(cnt_dir_up), 1);
    chk("R10 reset outputs", int'({pwm_a, pwm_b, evt_zero, evt_prd, sync_out}), 0);

    // R10 R8 default tables, rising mode period 4
    period = 4; cmp_a = 2; cmp_b = 3; run_en = 1;
    cyc(4);
    chk("R10 count at period", int'(cnt), 4);
    chk("R10 A high after match A", int'(pwm_a), 1);
    chk("R10 B high at period", int'(pwm_b), 1);
    chk("R7 period strobe", int'(evt_prd), 1);
    cyc(1);
    chk("R2 wrap to zero", int'(cnt), 0);
    chk("R10 A low at zero", int'(pwm_a), 0);
    chk("R7 zero strobe", int'(evt_zero), 1);

    // R1 prescaler: codes 1 and 1 give 4 cycles per step
    period = 100; hs_div_sel = 1; ck_div_sel = 1;
    phase_load(16'd0, 1'b1);
    run_en = 1;
    cyc(7);
    chk("R1 one step after 7 cycles", int'(cnt), 1);
    cyc(1);
    chk("R1 two steps after 8 cycles", int'(cnt), 2);

    // R5 hold
    run_en = 0;
    base = int'(cnt);
    cyc(10);
    chk("R5 frozen count", int'(cnt), base);

    // R9 priority: zero set beats B clear beats A toggle
    hs_div_sel = 0; ck_div_sel = 0; period = 3; cmp_a = 0; cmp_b = 0;
    act_a = 12'h132;
    phase_load(16'd3, 1'b1);
    run_en = 1;
    cyc(1);
    chk("R9 zero action wins", int'(pwm_a), 1);
    act_a = 12'h130;
    cyc(4);
    chk("R9 B clear beats A toggle", int'(pwm_a), 0);
    chk("R2 back at zero", int'(cnt), 0);

    // R6 direction after sync in rising-then-falling mode
    count_mode = 2'b10; period = 10;
    phase_load(16'd5, 1'b0);
    chk("R6 phase value loaded", int'(cnt), 5);
    run_en = 1; cyc(1);
    chk("R6 resumes downward", int'(cnt), 4);
    chk("R4 direction down", int'(cnt_dir_up), 0);
    phase_load(16'd5, 1'b1);
    run_en = 1; cyc(1);
    chk("R6 resumes upward", int'(cnt), 6);

    // R3 falling mode reload
    count_mode = 2'b01; period = 6;
    phase_load(16'd0, 1'b0);
    run_en = 1; cyc(1);
    chk("R3 reload period", int'(cnt), 6);

    // R11 pass-through
    run_en = 0; sync_out_sel = 2'b00; sw_sync = 1;
    cyc(1);
    sw_sync = 0;
    chk("R11 pass-through pulse", int'(sync_out), 1);
    cyc(1);
    chk("R11 pulse ends", int'(sync_out), 0);

    // random segments, dividers changed only while stopped
    for (int seg = 0; seg < 80; seg++) begin
      run_en = 0;
      hs_div_sel   = 3'($urandom % 3);
      ck_div_sel   = 3'($urandom % 3);
      count_mode   = 2'($urandom % 4);
      period       = 16'(1 + $urandom % 12);
      cmp_a        = 16'($urandom % 14);
      cmp_b        = 16'($urandom % 14);
      act_a        = 12'($urandom);
      act_b        = 12'($urandom);
      sync_out_sel = 2'($urandom % 4);
      phase_en     = 1'($urandom % 2);
      phase_val    = 16'($urandom % 15);
      phase_dir_up = 1'($urandom % 2);
      cyc(1);
      run_en = 1;
      for (int k = 0; k < 200; k++) begin
        sync_in = ($urandom % 40 == 0);
        sw_sync = ($urandom % 50 == 0);
        if ($urandom % 50 == 0) period = 16'(1 + $urandom % 12);
        if ($urandom % 50 == 0) cmp_a = 16'($urandom % 14);
        if ($urandom % 50 == 0) cmp_b = 16'($urandom % 14);
        if ($urandom % 100 == 0) count_mode = 2'($urandom % 4);
        if ($urandom % 60 == 0) begin
          hs_div_sel = 3'($urandom % 3);
          ck_div_sel = 3'($urandom % 3);
          run_en = 0;
        end else begin
          run_en = 1;
        end
        cyc(1);
      end
      sync_in = 0; sw_sync = 0;
    end
    cyc(2);
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule